// File: doc/BRIEF.md
# Vertical-First Mesh Stop Router

This block is one stop of a two-dimensional tiled fabric. It sits between a single tile and the four neighbouring stops to the north, south, east and west. It moves packets between those five ports. Each port, in either direction, is a valid/ready interface that carries one flit per transfer. A flit holds a destination row, a destination column and a payload. The stop is built once per tile, and parameters set the mesh size and the stop's own position.

Routing is dimension-ordered. A packet first runs along its column until it reaches the destination row, then runs along the row until it reaches the destination column. Rows and columns are open half rings, so the edge stops have no wraparound link. Because of this ordering, a request and its reply between the same two tiles pass through different stops.

Each input holds one packet in a single-entry buffer. The route is computed when the packet is written into that buffer. Each output has a round-robin arbiter. When the selected output is not ready, the packet stays in its buffer and back-pressure reaches the upstream sender through its ready signal.

Top module: `mstop_router`

## Requirements
- R1: Port indices are local=0, north=1, south=2, east=3, west=4. A flit is {dst_row, dst_col, payload}, with dst_row in the most significant COORD_W bits and payload in the least significant PAY_W bits. A packet with an in-range destination whose row differs from MY_ROW leaves on north when dst_row < MY_ROW and on south when dst_row > MY_ROW. Row index grows southward.
- R2: A packet with an in-range destination whose row equals MY_ROW leaves on west when dst_col < MY_COL and on east when dst_col > MY_COL. Column index grows eastward.
- R3: A packet addressed to (MY_ROW, MY_COL) leaves on the local output with out_local_err low.
- R4: A packet with dst_row >= ROWS or dst_col >= COLS is delivered on the local output with out_local_err high. out_local_err is never high while the local output is idle.
- R5: A packet arriving on the east or west input is never sent north or south. If its in-range destination row differs from MY_ROW, it is delivered locally with out_local_err high.
- R6: Each input holds at most one packet. in_ready is high when that entry is empty or is being forwarded in the same cycle, and low otherwise.
- R7: When several buffered packets target one output, the grant goes to the first requesting input after the last one granted on that output, in cyclic index order. After reset the search starts at input 0.
- R8: While an output is valid and not ready, its valid and flit hold unchanged. Every accepted packet is delivered exactly once.
- R9: A packet accepted at a clock edge appears on its output in the next cycle. After reset every output is idle and every input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-input packet valid, indexed by port |
| in_ready | output | 5 | Per-input ready |
| in_flit | input | 5*FLIT_W | Input flits, port p in bits [p*FLIT_W +: FLIT_W] |
| out_valid | output | 5 | Per-output packet valid |
| out_ready | input | 5 | Per-output ready from the receiver |
| out_flit | output | 5*FLIT_W | Output flits, same packing as in_flit |
| out_local_err | output | 1 | Qualifies the local output: the packet was undeliverable |

## Verification
The bench targets three kinds of corner case.

The first is coordinates at and beyond the mesh edges. A router that compared coordinates wrongly would send these packets toward an edge that has no link, and they would never return.

The second is horizontal arrivals with a mismatched row. A design that let these turn vertical would open a routing cycle.

The third is arbitration under stall. It fills all five buffers toward one blocked output and then toggles readiness at random. An arbiter that moved its pointer on a stall, or switched grants while an output was stalled, would break the expected order or change a held flit. A buffer that raised ready while full would overwrite a packet, and the final count of delivered packets would then fall short of the count accepted.

// File: rtl/mstop_pkg.sv
package mstop_pkg;
   localparam int NPORT = 5;

   typedef enum logic [2:0] {
      P_LOCAL = 3'd0,
      P_NORTH = 3'd1,
      P_SOUTH = 3'd2,
      P_EAST  = 3'd3,
      P_WEST  = 3'd4
   } port_e;
endpackage

// File: rtl/mstop_route.sv
module mstop_route
   import mstop_pkg::*;
#(
   parameter int ROWS     = 5,
   parameter int COLS     = 6,
   parameter int COORD_W  = 3,
   parameter int MY_ROW   = 2,
   parameter int MY_COL   = 3,
   parameter bit HORIZ_IN = 1'b0
) (
   input  logic [COORD_W-1:0] dst_row,
   input  logic [COORD_W-1:0] dst_col,
   output port_e              dir,
   output logic               err
);
   localparam logic [COORD_W:0]   ROWS_L = ROWS[COORD_W:0];
   localparam logic [COORD_W:0]   COLS_L = COLS[COORD_W:0];
   localparam logic [COORD_W-1:0] HERE_R = MY_ROW[COORD_W-1:0];
   localparam logic [COORD_W-1:0] HERE_C = MY_COL[COORD_W-1:0];

   logic off_mesh;
   logic row_hit;
   assign off_mesh = ({1'b0, dst_row} >= ROWS_L) || ({1'b0, dst_col} >= COLS_L);
   assign row_hit  = (dst_row == HERE_R);

   generate
      if (HORIZ_IN) begin : g_horiz
         // horizontal arrivals may only continue along the row or eject
         always_comb begin
            dir = P_LOCAL;
            err = 1'b0;
            if (off_mesh || !row_hit) begin
               err = 1'b1;
            end else if (dst_col < HERE_C) begin
               dir = P_WEST;
            end else if (dst_col > HERE_C) begin
               dir = P_EAST;
            end
         end
      end else begin : g_any
         always_comb begin
            dir = P_LOCAL;
            err = 1'b0;
            if (off_mesh) begin
               err = 1'b1;
            end else if (!row_hit) begin
               dir = (dst_row < HERE_R) ? P_NORTH : P_SOUTH;
            end else if (dst_col < HERE_C) begin
               dir = P_WEST;
            end else if (dst_col > HERE_C) begin
               dir = P_EAST;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mstop_inbuf.sv
module mstop_inbuf
   import mstop_pkg::*;
#(
   parameter int FLIT_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [FLIT_W-1:0] in_flit,
   input  port_e             in_dir,
   input  logic              in_err,
   input  logic              pop,
   output logic              full,
   output logic [FLIT_W-1:0] flit,
   output port_e             dir,
   output logic              err
);
   generate
      if (FLIT_W < 3) begin : g_bad_width
         $error("mstop_inbuf: FLIT_W too small");
      end
   endgenerate

   logic push;
   assign in_ready = !full || pop;
   assign push     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         flit <= '0;
         dir  <= P_LOCAL;
         err  <= 1'b0;
      end else if (push) begin
         full <= 1'b1;
         flit <= in_flit;
         dir  <= in_dir;
         err  <= in_err;
      end else if (pop) begin
         full <= 1'b0;
      end
   end

   p_hold_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> (full && $stable(flit) && $stable(dir)));
   p_pop_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> full);
endmodule

// File: rtl/mstop_rr_arb.sv
module mstop_rr_arb #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         out_ready,
   output logic [N-1:0] grant
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   generate
      if (N < 2) begin : g_bad_n
         $error("mstop_rr_arb: needs at least two requesters");
      end
   endgenerate

   logic [IW-1:0] last_q;
   logic          locked_q;
   logic [N-1:0]  held_q;
   logic [N-1:0]  rr_gnt;
   logic          found;

   always_comb begin
      rr_gnt = '0;
      found  = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!found && req[i] && (i > int'(last_q))) begin
            rr_gnt[i] = 1'b1;
            found     = 1'b1;
         end
      end
      for (int i = 0; i < N; i++) begin
         if (!found && req[i] && (i <= int'(last_q))) begin
            rr_gnt[i] = 1'b1;
            found     = 1'b1;
         end
      end
   end

   assign grant = locked_q ? held_q : rr_gnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q   <= IW'(N - 1);
         locked_q <= 1'b0;
         held_q   <= '0;
      end else if (|grant) begin
         if (out_ready) begin
            locked_q <= 1'b0;
            for (int i = 0; i < N; i++) begin
               if (grant[i]) last_q <= IW'(i);
            end
         end else begin
            locked_q <= 1'b1;
            held_q   <= grant;
         end
      end
   end

   p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_grant_has_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |-> ((grant & ~req) == '0));
   p_stall_keeps_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|grant) && !out_ready) |=> (grant == $past(grant)));
endmodule

// File: rtl/mstop_router.sv
module mstop_router
   import mstop_pkg::*;
#(
   parameter int ROWS    = 5,
   parameter int COLS    = 6,
   parameter int COORD_W = 3,
   parameter int PAY_W   = 8,
   parameter int MY_ROW  = 2,
   parameter int MY_COL  = 3,
   localparam int FLIT_W = 2 * COORD_W + PAY_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [4:0]              in_valid,
   output logic [4:0]              in_ready,
   input  logic [5*FLIT_W-1:0]     in_flit,
   output logic [4:0]              out_valid,
   input  logic [4:0]              out_ready,
   output logic [5*FLIT_W-1:0]     out_flit,
   output logic                    out_local_err
);
   localparam int ROW_LSB = PAY_W + COORD_W;
   localparam int COL_LSB = PAY_W;

   generate
      if (ROWS < 1 || COLS < 1) begin : g_bad_dims
         $error("mstop_router: mesh dimensions must be positive");
      end
      if ((1 << COORD_W) < ROWS || (1 << COORD_W) < COLS) begin : g_bad_coord
         $error("mstop_router: COORD_W too narrow for mesh");
      end
      if (MY_ROW < 0 || MY_ROW >= ROWS || MY_COL < 0 || MY_COL >= COLS) begin : g_bad_pos
         $error("mstop_router: stop position outside mesh");
      end
      if (PAY_W < 1) begin : g_bad_pay
         $error("mstop_router: PAY_W must be positive");
      end
   endgenerate

   logic [NPORT-1:0]  buf_full;
   logic [NPORT-1:0]  buf_err;
   logic [NPORT-1:0]  pop;
   logic [FLIT_W-1:0] buf_flit [NPORT];
   port_e             buf_dir  [NPORT];
   logic [NPORT-1:0]  req      [NPORT];
   logic [NPORT-1:0]  gnt      [NPORT];

   // input side: route at enqueue, then one-entry hold
   for (genvar i = 0; i < NPORT; i++) begin : g_in
      logic [FLIT_W-1:0] flit_i;
      port_e             rdir;
      logic              rerr;
      assign flit_i = in_flit[i*FLIT_W +: FLIT_W];

      mstop_route #(
         .ROWS     (ROWS),
         .COLS     (COLS),
         .COORD_W  (COORD_W),
         .MY_ROW   (MY_ROW),
         .MY_COL   (MY_COL),
         .HORIZ_IN ((i == int'(P_EAST)) || (i == int'(P_WEST)))
      ) u_route (
         .dst_row (flit_i[ROW_LSB +: COORD_W]),
         .dst_col (flit_i[COL_LSB +: COORD_W]),
         .dir     (rdir),
         .err     (rerr)
      );

      mstop_inbuf #(.FLIT_W(FLIT_W)) u_buf (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_valid[i]),
         .in_ready (in_ready[i]),
         .in_flit  (flit_i),
         .in_dir   (rdir),
         .in_err   (rerr),
         .pop      (pop[i]),
         .full     (buf_full[i]),
         .flit     (buf_flit[i]),
         .dir      (buf_dir[i]),
         .err      (buf_err[i])
      );
   end

   // output side: request matrix, arbiter and mux per output
   for (genvar o = 0; o < NPORT; o++) begin : g_out
      for (genvar i = 0; i < NPORT; i++) begin : g_req
         assign req[o][i] = buf_full[i] && (buf_dir[i] == port_e'(o));
      end

      mstop_rr_arb #(.N(NPORT)) u_arb (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req[o]),
         .out_ready (out_ready[o]),
         .grant     (gnt[o])
      );

      logic [FLIT_W-1:0] sel;
      always_comb begin
         sel = '0;
         for (int i = 0; i < NPORT; i++) begin
            if (gnt[o][i]) sel = sel | buf_flit[i];
         end
      end
      assign out_valid[o]                  = |gnt[o];
      assign out_flit[o*FLIT_W +: FLIT_W]  = sel;

      p_stable_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[o] && !out_ready[o]) |=>
            (out_valid[o] && $stable(out_flit[o*FLIT_W +: FLIT_W])));
   end

   always_comb begin
      pop = '0;
      for (int i = 0; i < NPORT; i++) begin
         for (int o = 0; o < NPORT; o++) begin
            if (gnt[o][i] && out_ready[o]) pop[i] = 1'b1;
         end
      end
   end

   always_comb begin
      out_local_err = 1'b0;
      for (int i = 0; i < NPORT; i++) begin
         if (gnt[0][i] && buf_err[i]) out_local_err = 1'b1;
      end
   end

   p_err_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_local_err |-> out_valid[0]);
   p_no_turn_east_r5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full[P_EAST] |-> (buf_dir[P_EAST] != P_NORTH && buf_dir[P_EAST] != P_SOUTH));
   p_no_turn_west_r5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full[P_WEST] |-> (buf_dir[P_WEST] != P_NORTH && buf_dir[P_WEST] != P_SOUTH));
   p_accept_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[0] && in_ready[0]) |=> buf_full[0]);
endmodule

// File: tb/mstop_router_bench.sv
`timescale 1ns/1ps
module mstop_router_bench;
   localparam int ROWS = 5, COLS = 6, CW = 3, PW = 8, MR = 2, MC = 3;
   localparam int FW = 2 * CW + PW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [4:0]      in_valid = '0;
   logic [4:0]      in_ready;
   logic [5*FW-1:0] in_flit = '0;
   logic [4:0]      out_valid;
   logic [4:0]      out_ready = '0;
   logic [5*FW-1:0] out_flit;
   logic            out_local_err;

   always #2 clk = ~clk;

   mstop_router #(.ROWS(ROWS), .COLS(COLS), .COORD_W(CW), .PAY_W(PW),
                  .MY_ROW(MR), .MY_COL(MC)) u_mstop_router (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready),
      .out_flit(out_flit), .out_local_err(out_local_err));

   int total = 0, bad = 0, accepted = 0, delivered = 0;
   bit          mfull [5];
   logic [FW-1:0] mflit [5];
   int          mdir  [5];
   bit          merr  [5];
   int          mptr  [5];
   bit          mlk   [5];
   int          mlki  [5];

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int ref_route(int inp, logic [FW-1:0] f, output bit e);
      int r, c;
      r = int'(f[FW-1 -: CW]);
      c = int'(f[PW +: CW]);
      e = 1'b0;
      if (r >= ROWS || c >= COLS) begin e = 1'b1; return 0; end
      if (r != MR) begin
         if (inp == 3 || inp == 4) begin e = 1'b1; return 0; end
         return (r < MR) ? 1 : 2;
      end
      if (c < MC) return 4;
      if (c > MC) return 3;
      return 0;
   endfunction

   function automatic string tag_of(int o);
      if (o == 0) return "R3";
      if (o == 1 || o == 2) return "R1";
      return "R2";
   endfunction

   // compare model to DUT in this cycle, then advance the model at the edge
   task automatic step();
      int g [5];
      bit pp [5];
      bit er [5];
      #1;
      for (int i = 0; i < 5; i++) pp[i] = 1'b0;
      for (int o = 0; o < 5; o++) begin
         g[o] = -1;
         if (mlk[o]) g[o] = mlki[o];
         else begin
            for (int k = 1; k <= 5; k++) begin
               int i;
               i = (mptr[o] + k) % 5;
               if (g[o] < 0 && mfull[i] && mdir[i] == o) g[o] = i;
            end
         end
         if (g[o] >= 0 && out_ready[o]) pp[g[o]] = 1'b1;
         chk(out_valid[o] == (g[o] >= 0), tag_of(o), "out_valid", int'(out_valid[o]), int'(g[o] >= 0));
         if (g[o] >= 0)
            chk(out_flit[o*FW +: FW] == mflit[g[o]], "R7", "out_flit",
                int'(out_flit[o*FW +: FW]), int'(mflit[g[o]]));
      end
      chk(out_local_err == (g[0] >= 0 && merr[g[0]]), "R4", "out_local_err",
          int'(out_local_err), int'(g[0] >= 0 && merr[g[0]]));
      for (int i = 0; i < 5; i++) begin
         er[i] = !mfull[i] || pp[i];
         chk(in_ready[i] == er[i], "R6", "in_ready", int'(in_ready[i]), int'(er[i]));
      end
      @(posedge clk);
      for (int o = 0; o < 5; o++) begin
         if (g[o] >= 0) begin
            if (out_ready[o]) begin
               mfull[g[o]] = 1'b0; mptr[o] = g[o]; mlk[o] = 1'b0; delivered++;
            end else begin
               mlk[o] = 1'b1; mlki[o] = g[o];
            end
         end
      end
      for (int i = 0; i < 5; i++) begin
         if (in_valid[i] && er[i]) begin
            bit e;
            mfull[i] = 1'b1;
            mflit[i] = in_flit[i*FW +: FW];
            mdir[i]  = ref_route(i, mflit[i], e);
            merr[i]  = e;
            accepted++;
         end
      end
      @(negedge clk);
   endtask

   function automatic logic [FW-1:0] mk(int r, int c, int p);
      return {CW'(r), CW'(c), PW'(p)};
   endfunction

   task automatic route_case(int inp, int r, int c, int ep, bit ee, string tag);
      logic [FW-1:0] f;
      f = mk(r, c, 8'h5A + inp);
      out_ready = 5'h1f;
      in_valid = 5'(1 << inp);
      in_flit[inp*FW +: FW] = f;
      step();
      in_valid = '0;
      #1;
      chk(out_valid == 5'(1 << ep), tag, "route port", int'(out_valid), 1 << ep);
      chk(out_flit[ep*FW +: FW] == f, tag, "route flit", int'(out_flit[ep*FW +: FW]), int'(f));
      chk(out_local_err == ee, tag, "route err", int'(out_local_err), int'(ee));
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 5; i++) begin
         mfull[i] = 0; mflit[i] = '0; mdir[i] = 0; merr[i] = 0;
         mptr[i] = 4; mlk[i] = 0; mlki[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(out_valid == 5'h00, "R9", "reset out_valid", int'(out_valid), 0);
      chk(in_ready == 5'h1f, "R9", "reset in_ready", int'(in_ready), 31);
      @(negedge clk);

      route_case(0, 2, 3, 0, 1'b0, "R3");
      route_case(0, 0, 5, 1, 1'b0, "R1");
      route_case(1, 4, 0, 2, 1'b0, "R1");
      route_case(0, 2, 5, 3, 1'b0, "R2");
      route_case(2, 2, 0, 4, 1'b0, "R2");
      route_case(4, 2, 5, 3, 1'b0, "R2");
      route_case(0, 5, 1, 0, 1'b1, "R4");
      route_case(1, 1, 6, 0, 1'b1, "R4");
      route_case(3, 0, 3, 0, 1'b1, "R5");
      route_case(4, 4, 1, 0, 1'b1, "R5");

      // fill all buffers toward a blocked local output
      out_ready = 5'h00;
      in_valid = 5'h1f;
      for (int i = 0; i < 5; i++) in_flit[i*FW +: FW] = mk(2, 3, 16 + i);
      step();
      in_valid = '0;
      #1;
      chk(in_ready == 5'h00, "R6", "full buffers not ready", int'(in_ready), 0);
      step();
      step();
      out_ready = 5'h1f;
      for (int k = 0; k < 6; k++) step();

      // random traffic with random back-pressure
      for (int n = 0; n < 4000; n++) begin
         for (int i = 0; i < 5; i++)
            in_flit[i*FW +: FW] = mk($urandom_range(0, 5), $urandom_range(0, 6),
                                     $urandom_range(0, 255));
         in_valid  = 5'($urandom);
         out_ready = 5'($urandom) | 5'($urandom);
         step();
      end
      in_valid = '0;
      out_ready = 5'h1f;
      for (int k = 0; k < 20; k++) step();
      chk(accepted == delivered, "R8", "accepted vs delivered", delivered, accepted);
      chk(out_valid == 5'h00, "R8", "drained", int'(out_valid), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule